// File: doc/BRIEF.md
# Constant-Time Binary Field Divider

This block returns the quotient of two elements of the binary extension field GF(2^M). It does not compute an inverse and then multiply. It runs a right-shifting extended binary GCD that carries the dividend through the whole iteration, so the final accumulator holds the quotient itself.

Elements are M-bit vectors in polynomial basis. Bit i is the coefficient of x^i. The reduction polynomial is the parameter `POLY`, which is M+1 bits wide and has bit M and bit 0 set.

Every operation takes 2M-1 iterations, one per clock, whatever the operand values. This keeps the timing free of any data dependence, as needed inside point-arithmetic engines that must not leak operand bits through timing. A divisor of zero is outside the block's contract.

The controller has three states:
- `ST_IDLE` waits for `start`.
- `ST_RUN` performs one iteration per cycle.
- `ST_DONE` lasts one cycle and raises `done`.

Its transitions are:
- idle→run, taken when `start` is seen.
- run→done, taken on the last iteration.
- done→idle, taken when `start` is low.
- done→run, taken when `start` is high.

While in `ST_RUN` the controller holds a divisor-side pair, a modulus-side pair and a signed degree-difference counter. The divisor-side pair is (A, U) and the modulus-side pair is (B, V). These are loaded with (divisor, dividend), (POLY, 0) and -1.

Top module: `gf_divider`

## Requirements
- R1: While `rst_n` is low and after it rises, `done` is 0 and `quotient` is 0 until the first operation completes.
- R2: For a nonzero divisor b and any dividend a, the `quotient` q presented with `done` satisfies q·b ≡ a modulo POLY. Here bit i of each vector is the coefficient of x^i, and POLY = x^163+x^7+x^6+x^3+1 by default.
- R3: `done` rises exactly 2M-1 clock edges after the edge that accepts `start`, for every operand pair.
- R4: `done` is high for exactly one cycle per operation.
- R5: `quotient` changes only on the edge that raises `done`. It holds its value through idle cycles and through the whole of the next operation.
- R6: A `start` pulse seen while in `ST_RUN` is ignored. The running operation keeps its operands, its result and its completion time.
- R7: Corner operands: a dividend of 0 gives 0, a divisor of 1 gives the dividend, and equal operands give 1.
- R8: `start` is accepted during the `ST_DONE` cycle, so operations can run back to back with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; sampled in `ST_IDLE` and `ST_DONE` |
| dividend | input | M | Numerator a, captured with `start` |
| divisor | input | M | Denominator b (nonzero), captured with `start` |
| quotient | output | M | a/b, valid from `done` until the next completion |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some properties are asserted on every cycle:
- the 2M-1 edge distance from acceptance to `done`;
- the single-cycle `done` pulse;
- the stability of `quotient` outside the final iteration;
- the controller staying in `ST_RUN` when `start` arrives mid-operation;
- the modulus-side polynomial always being odd, which the correctness argument relies on.

The arithmetic result can only be shown by the bench scenarios. The bench computes a reference quotient through a Fermat-power inverse and also checks q·b against a. It covers the corner operands, an injected mid-run `start`, and back-to-back operations.

// File: rtl/gf_div_pkg.sv
package gf_div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } div_state_t;
endpackage

// File: rtl/gf_div_step.sv
// One iteration of the right-shifting extended binary GCD, carrying the dividend.
module gf_div_step #(
    parameter int        M    = 163,
    parameter logic [M:0] POLY = {1'b1, (M)'('hC9)},
    parameter int        DW   = 11
) (
    input  logic [M-1:0]          a_i,
    input  logic [M:0]            b_i,
    input  logic [M-1:0]          u_i,
    input  logic [M-1:0]          v_i,
    input  logic signed [DW-1:0]  d_i,
    output logic [M-1:0]          a_o,
    output logic [M:0]            b_o,
    output logic [M-1:0]          u_o,
    output logic [M-1:0]          v_o,
    output logic signed [DW-1:0]  d_o
);
    logic         odd;
    logic         swap;
    logic [M:0]   a_sum;
    logic [M-1:0] u_sum;
    logic [M:0]   u_red;

    always_comb begin
        odd   = a_i[0];
        swap  = odd && d_i[DW-1];
        a_sum = odd ? ({1'b0, a_i} ^ b_i) : {1'b0, a_i};
        u_sum = odd ? (u_i ^ v_i) : u_i;
        u_red = u_sum[0] ? ({1'b0, u_sum} ^ POLY) : {1'b0, u_sum};
        a_o   = a_sum[M:1];
        u_o   = u_red[M:1];
        b_o   = swap ? {1'b0, a_i} : b_i;
        v_o   = swap ? u_i : v_i;
        d_o   = (swap ? -d_i : d_i) - DW'(1);
    end
endmodule

// File: rtl/gf_div_ctr.sv
// Iteration counter; flags the final iteration of a fixed-length run.
module gf_div_ctr #(
    parameter int LIMIT = 325,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (en)
            cnt_q <= cnt_q + CW'(1);
    end

    always_comb last = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/gf_divider.sv
module gf_divider
    import gf_div_pkg::*;
#(
    parameter int        M    = 163,
    parameter logic [M:0] POLY = {1'b1, (M)'('hC9)}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] dividend,
    input  logic [M-1:0] divisor,
    output logic [M-1:0] quotient,
    output logic         done
);
    localparam int LAT = 2 * M - 1;
    localparam int DW  = $clog2(2 * M) + 2;
    localparam int LW  = $clog2(LAT + 1) + 1;

    div_state_t state_q, state_n;
    logic       accept, last;

    logic [M-1:0]         a_q, u_q, v_q, quo_q;
    logic [M:0]           b_q;
    logic signed [DW-1:0] d_q;
    logic [M-1:0]         a_n, u_n, v_n;
    logic [M:0]           b_n;
    logic signed [DW-1:0] d_n;

    always_comb accept = start && (state_q != ST_RUN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_n = ST_RUN;
            ST_RUN:  if (last)  state_n = ST_DONE;
            ST_DONE: state_n = start ? ST_RUN : ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        done     = (state_q == ST_DONE);
        quotient = quo_q;
    end

    gf_div_ctr #(.LIMIT(LAT)) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (accept),
        .en   (state_q == ST_RUN),
        .last (last)
    );

    gf_div_step #(.M(M), .POLY(POLY), .DW(DW)) u_step (
        .a_i(a_q), .b_i(b_q), .u_i(u_q), .v_i(v_q), .d_i(d_q),
        .a_o(a_n), .b_o(b_n), .u_o(u_n), .v_o(v_n), .d_o(d_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= POLY;
            u_q   <= '0;
            v_q   <= '0;
            d_q   <= '1;
            quo_q <= '0;
        end else if (accept) begin
            a_q <= divisor;
            b_q <= POLY;
            u_q <= dividend;
            v_q <= '0;
            d_q <= '1;
        end else if (state_q == ST_RUN) begin
            a_q <= a_n;
            b_q <= b_n;
            u_q <= u_n;
            v_q <= v_n;
            d_q <= d_n;
            if (last) quo_q <= v_n;
        end
    end

    // cycles since acceptance, kept for the latency check
    logic [LW-1:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  lat_q <= '0;
        else if (accept)             lat_q <= '0;
        else if (state_q == ST_RUN)  lat_q <= lat_q + LW'(1);
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!done && quotient == '0));

    // R3
    fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == LW'(LAT)));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    quotient_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN) |=> $stable(quotient));

    // R6
    run_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !last) |=> (state_q == ST_RUN));

    // R2
    modulus_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> b_q[0]);
endmodule

// File: tb/gf_divider_test.sv
module gf_divider_test;
    localparam int         M    = 163;
    localparam logic [M:0] POLY = {1'b1, (M)'('hC9)};
    localparam int         LAT  = 2 * M - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [M-1:0] dividend = '0;
    logic [M-1:0] divisor = '0;
    logic [M-1:0] quotient;
    logic         done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    gf_divider uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(dividend), .divisor(divisor),
        .quotient(quotient), .done(done)
    );

    always #4 clk = ~clk;

    function automatic logic [M-1:0] fmul(input logic [M-1:0] x, input logic [M-1:0] y);
        logic [M-1:0] r = '0;
        for (int i = M - 1; i >= 0; i--) begin
            r = r[M-1] ? ((r << 1) ^ POLY[M-1:0]) : (r << 1);
            if (y[i]) r = r ^ x;
        end
        return r;
    endfunction

    // b^(2^M - 2) as the product of b^(2^i), i = 1..M-1
    function automatic logic [M-1:0] finv(input logic [M-1:0] y);
        logic [M-1:0] s = y;
        logic [M-1:0] acc = M'(1);
        for (int i = 1; i < M; i++) begin
            s   = fmul(s, s);
            acc = fmul(acc, s);
        end
        return acc;
    endfunction

    function automatic logic [M-1:0] rnd_elem();
        logic [M-1:0] r = '0;
        for (int i = 0; i < (M + 31) / 32; i++) r = {r[M-33:0], 32'($urandom)};
        if (r == '0) r = M'(1);
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [M-1:0] act, input logic [M-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic launch(input logic [M-1:0] a, input logic [M-1:0] b);
        dividend = a;
        divisor  = b;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    // Cycle-by-cycle model: done low and quotient at its old value until edge LAT.
    task automatic track(input logic [M-1:0] a, input logic [M-1:0] b,
                         input logic [M-1:0] prev_q, input bit inject, input string tag);
        logic [M-1:0] exp_q = fmul(a, finv(b));
        for (int k = 1; k <= LAT; k++) begin
            if (inject && k == 5) begin
                start = 1'b1; dividend = ~a; divisor = M'(1);
            end
            if (inject && k == 6) start = 1'b0;
            @(negedge clk);
            if (k < LAT) begin
                chk(done == 1'b0, {tag, " R3 early done"}, M'(done), M'(0));
                chk(quotient == prev_q, {tag, " R5 quotient held in run"}, quotient, prev_q);
            end else begin
                chk(done == 1'b1, {tag, " R3 done at 2M-1"}, M'(done), M'(1));
                chk(quotient == exp_q, {tag, " R2 quotient"}, quotient, exp_q);
                chk(fmul(quotient, b) == a, {tag, " R2 q*b==a"}, fmul(quotient, b), a);
            end
        end
    endtask

    task automatic after_done(input logic [M-1:0] q, input int idle, input string tag);
        for (int k = 0; k < idle; k++) begin
            @(negedge clk);
            chk(done == 1'b0, {tag, " R4 single pulse"}, M'(done), M'(0));
            chk(quotient == q, {tag, " R5 hold"}, quotient, q);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [M-1:0] a, b, a2, b2, q;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done in reset", M'(done), M'(0));
        chk(quotient == '0, "R1 quotient in reset", quotient, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && quotient == '0, "R1 after reset", quotient, '0);

        a = rnd_elem(); b = rnd_elem();
        launch(a, b); track(a, b, '0, 1'b0, "rand0");
        q = fmul(a, finv(b)); after_done(q, 3, "rand0");

        // R7 corner operands
        launch(a, M'(1)); track(a, M'(1), q, 1'b0, "R7 div1");
        chk(quotient == a, "R7 b=1 gives a", quotient, a);
        q = a; after_done(q, 1, "R7 div1");
        b = rnd_elem();
        launch(b, b); track(b, b, q, 1'b0, "R7 self");
        chk(quotient == M'(1), "R7 a=b gives 1", quotient, M'(1));
        q = M'(1); after_done(q, 1, "R7 self");
        launch('0, b); track('0, b, q, 1'b0, "R7 zero");
        chk(quotient == '0, "R7 a=0 gives 0", quotient, '0);
        q = '0; after_done(q, 1, "R7 zero");

        // high-degree divisor
        a = '1; b = M'(1) << (M - 1);
        launch(a, b); track(a, b, q, 1'b0, "topbit");
        q = fmul(a, finv(b)); after_done(q, 2, "topbit");

        // R6 start while running
        a = rnd_elem(); b = rnd_elem();
        launch(a, b); track(a, b, q, 1'b1, "R6 inject");
        q = fmul(a, finv(b)); after_done(q, 4, "R6 inject");

        // R8 back to back
        a = rnd_elem(); b = rnd_elem(); a2 = rnd_elem(); b2 = rnd_elem();
        launch(a, b); track(a, b, q, 1'b0, "R8 first");
        q = fmul(a, finv(b));
        launch(a2, b2);
        chk(done == 1'b0, "R8 R4 pulse ends", M'(done), M'(0));
        track(a2, b2, q, 1'b0, "R8 second");
        q = fmul(a2, finv(b2)); after_done(q, 2, "R8 second");

        for (int n = 0; n < 5; n++) begin
            a = rnd_elem(); b = rnd_elem();
            launch(a, b); track(a, b, q, 1'b0, "rand");
            q = fmul(a, finv(b)); after_done(q, 1 + n, "rand");
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule